// File: doc/BRIEF.md
# Cache-Safe Split-Port Register Bank

This block decodes a 32-bit expansion-bus address window and holds the register set of a peripheral. The layout keeps a caching CPU from corrupting device state. Each read/write control register has two ports. One address returns its value and ignores writes. A second address, in another 256-byte page, accepts writes and reads back as zero. A CPU that allocates a cache line on a longword write therefore caches only the write address. A later read goes to the separate read address and still reaches the hardware.

Trigger registers have a side effect when read: each read hands over the next value from a small FIFO that device logic fills. Each trigger register is the only register in its own 16-byte block. A burst line fill that touches a neighbouring word cannot pop it by accident. Every access that falls in the window returns an acknowledge and a cache-inhibit flag in the cycle after it is sampled. A read returns its data in that same cycle.

The address window is 4 KiB, set by `ADDR_W`, and starts at `BASE`. Within the window there are three pages:
- Page 0, offsets 0x000–0x0FF: read ports.
- Page 1, offsets 0x100–0x1FF: write ports.
- Page 2, offsets 0x200–0x2FF: trigger blocks.

Top module: `split_port_regbank`

## Requirements
- R1: When `bus_sel` is sampled high with `bus_addr[31:ADDR_W]` equal to `BASE[31:ADDR_W]`, both `bus_ack` and `bus_cinh` are 1 in the following cycle. When the upper bits do not match, both are 0 and `bus_rdata` is 0.
- R2: A write to window offset 0x100 + 4·i, for i < NUM_RW, loads `bus_wdata` into control register i. The new value shows on `cfg_q[i*DATA_W +: DATA_W]` in the next cycle.
- R3: A read at window offset 0x000 + 4·i, for i < NUM_RW, returns control register i on `bus_rdata` in the next cycle.
- R4: A read at a write-port offset returns 0 and changes no register. A write at a read-port offset changes no control register.
- R5: A read at window offset 0x200 + 16·t, for t < NUM_TRIG, returns the oldest value pending in trigger FIFO t and removes that value.
- R6: A trigger read while its FIFO is empty returns 0. It also sets `trig_underflow[t]`, which stays set until reset.
- R7: The other three longwords of each trigger block (offsets +4, +8 and +12) read as 0 and do not pop the FIFO.
- R8: A read at an unmapped offset returns 0 and has no side effect. Unmapped offsets are: a misaligned address (`bus_addr[1:0]` ≠ 0), page 3 or above, or an index at or beyond the register count.
- R9: Each trigger FIFO holds FIFO_DEPTH entries. `dev_full[t]` is 1 while it is full, and a `dev_push[t]` while full is dropped.
- R10: After reset, all control registers are 0, all FIFOs are empty, `trig_underflow` is 0, and `bus_ack` and `bus_cinh` are 0.
- R11: A write to a trigger address neither pops nor changes that FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_ack | output | 1 | Access accepted, one cycle after strobe |
| bus_cinh | output | 1 | Cache inhibit, same cycle as `bus_ack` |
| bus_rdata | output | DATA_W | Read data, same cycle as `bus_ack` |
| cfg_q | output | NUM_RW*DATA_W | Control register values for the device |
| dev_push | input | NUM_TRIG | Device push strobe per trigger FIFO |
| dev_data | input | NUM_TRIG*DATA_W | Device push data per trigger FIFO |
| dev_full | output | NUM_TRIG | FIFO full per trigger register |
| trig_underflow | output | NUM_TRIG | Sticky empty-read flag per trigger register |

## Verification
The bench builds the block with six control registers, three trigger registers and four-deep FIFOs. With six registers, the read and write pages contain mapped indices and also unmapped indices 6 and 7. With three trigger registers, trigger block 3 is unmapped while lying in the same page as mapped blocks. A depth of four is small enough that random pushes fill a FIFO and reach the drop case. Random reads drain FIFOs past empty, which sets the underflow flags.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int RW_IDX_W   = 6;
  localparam int TRIG_IDX_W = 4;

  typedef struct packed {
    logic                  rd_rw;
    logic                  wr_rw;
    logic                  trig;
    logic [RW_IDX_W-1:0]   rw_idx;
    logic [TRIG_IDX_W-1:0] trig_idx;
  } dec_t;
endpackage

// File: rtl/addr_map_dec.sv
module addr_map_dec
  import regbank_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter logic [31:0] BASE     = 32'h4000_0000,
  parameter int          NUM_RW   = 6,
  parameter int          NUM_TRIG = 3
) (
  input  logic [31:0] addr,
  output logic        hit,
  output dec_t        dec
);
  localparam int PG_W = ADDR_W - 8;

  logic [PG_W-1:0]       page;
  logic [RW_IDX_W-1:0]   word;
  logic [TRIG_IDX_W-1:0] blk;
  logic                  aligned;

  always_comb begin
    page    = addr[ADDR_W-1:8];
    word    = addr[7:2];
    blk     = addr[7:4];
    aligned = (addr[1:0] == 2'b00);
    hit     = (addr[31:ADDR_W] == BASE[31:ADDR_W]);

    dec.rw_idx   = word;
    dec.trig_idx = blk;
    dec.rd_rw    = hit && aligned && (page == PG_W'(0)) && (32'(word) < NUM_RW);
    dec.wr_rw    = hit && aligned && (page == PG_W'(1)) && (32'(word) < NUM_RW);
    dec.trig     = hit && aligned && (page == PG_W'(2)) && (addr[3:2] == 2'b00)
                   && (32'(blk) < NUM_TRIG);
  end
endmodule

// File: rtl/trig_fifo.sv
module trig_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic              full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wp, rp;
  logic [CW-1:0]     cnt;
  logic              do_push, do_pop;

  assign empty   = (cnt == CW'(0));
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (!do_push && do_pop) cnt <= cnt - 1'b1;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH)) else $error("fifo count above depth"); // R9
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> (cnt == CW'(DEPTH))) else $error("push while full changed count"); // R9
  AST_NO_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty) else $error("pop request on empty fifo"); // R6
endmodule

// File: rtl/split_port_regbank.sv
module split_port_regbank
  import regbank_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          ADDR_W     = 12,
  parameter logic [31:0] BASE       = 32'h4000_0000,
  parameter int          NUM_RW     = 6,
  parameter int          NUM_TRIG   = 3,
  parameter int          FIFO_DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_sel,
  input  logic                       bus_we,
  input  logic [31:0]                bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic                       bus_ack,
  output logic                       bus_cinh,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic [NUM_RW*DATA_W-1:0]   cfg_q,
  input  logic [NUM_TRIG-1:0]        dev_push,
  input  logic [NUM_TRIG*DATA_W-1:0] dev_data,
  output logic [NUM_TRIG-1:0]        dev_full,
  output logic [NUM_TRIG-1:0]        trig_underflow
);
  logic              hit;
  dec_t              dec;
  logic              rd_acc, wr_acc;
  logic [DATA_W-1:0] cfg   [NUM_RW];
  logic [DATA_W-1:0] thead [NUM_TRIG];
  logic [NUM_TRIG-1:0] tempty, tpop, tsel;
  logic [DATA_W-1:0] rd_mux;

  addr_map_dec #(
    .ADDR_W(ADDR_W), .BASE(BASE), .NUM_RW(NUM_RW), .NUM_TRIG(NUM_TRIG)
  ) u_dec (
    .addr(bus_addr), .hit(hit), .dec(dec)
  );

  assign rd_acc = bus_sel && !bus_we && hit;
  assign wr_acc = bus_sel &&  bus_we && hit;

  for (genvar i = 0; i < NUM_RW; i++) begin : g_rw
    always_ff @(posedge clk) begin
      if (rst) cfg[i] <= '0;
      else if (wr_acc && dec.wr_rw && dec.rw_idx == RW_IDX_W'(i)) cfg[i] <= bus_wdata;
    end
    assign cfg_q[i*DATA_W +: DATA_W] = cfg[i];
  end

  for (genvar t = 0; t < NUM_TRIG; t++) begin : g_trig
    assign tsel[t] = rd_acc && dec.trig && dec.trig_idx == TRIG_IDX_W'(t);
    assign tpop[t] = tsel[t] && !tempty[t];

    trig_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst(rst),
      .push(dev_push[t]), .push_data(dev_data[t*DATA_W +: DATA_W]),
      .pop(tpop[t]), .head(thead[t]), .empty(tempty[t]), .full(dev_full[t])
    );

    always_ff @(posedge clk) begin
      if (rst) trig_underflow[t] <= 1'b0;
      else if (tsel[t] && tempty[t]) trig_underflow[t] <= 1'b1;
    end

    AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
      trig_underflow[t] |=> trig_underflow[t]) else $error("underflow flag cleared"); // R6
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_RW; i++)
      if (dec.rd_rw && dec.rw_idx == RW_IDX_W'(i)) rd_mux = cfg[i];
    for (int t = 0; t < NUM_TRIG; t++)
      if (tpop[t]) rd_mux = thead[t];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ack   <= 1'b0;
      bus_cinh  <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack   <= bus_sel && hit;
      bus_cinh  <= bus_sel && hit;
      bus_rdata <= rd_acc ? rd_mux : '0;
    end
  end

  AST_CINH_ON_HIT: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && hit) |=> bus_cinh) else $error("cache inhibit missing"); // R1
  AST_WR_PORT_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_acc && dec.wr_rw) |=> (bus_rdata == '0)) else $error("write port returned data"); // R4
  AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !(wr_acc && dec.wr_rw) |=> $stable(cfg_q)) else $error("register changed without write"); // R4
endmodule

// File: tb/tb_split_port_regbank.sv
`timescale 1ns/1ps
module tb_split_port_regbank;
  localparam int DW = 32, NRW = 6, NTR = 3, DEP = 4;

  logic clk = 0, rst = 1;
  logic bus_sel = 0, bus_we = 0;
  logic [31:0] bus_addr = 0, bus_wdata = 0;
  logic bus_ack, bus_cinh;
  logic [DW-1:0] bus_rdata;
  logic [NRW*DW-1:0] cfg_q;
  logic [NTR-1:0] dev_push = 0;
  logic [NTR*DW-1:0] dev_data = 0;
  logic [NTR-1:0] dev_full, trig_underflow;

  always #2.5 clk = ~clk;

  split_port_regbank #(.DATA_W(DW), .ADDR_W(12), .BASE(32'h4000_0000),
    .NUM_RW(NRW), .NUM_TRIG(NTR), .FIFO_DEPTH(DEP)) dut (.*);

  int checks = 0, failures = 0;
  logic [31:0] cfg_m [NRW];
  logic [31:0] fq [NTR][DEP];
  int fc [NTR];
  logic [NTR-1:0] uf_m;

  task automatic check(string req, logic [191:0] act, logic [191:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NRW*DW-1:0] cfg_flat();
    logic [NRW*DW-1:0] v;
    for (int i = 0; i < NRW; i++) v[i*DW +: DW] = cfg_m[i];
    return v;
  endfunction

  function automatic logic [NTR-1:0] full_m();
    logic [NTR-1:0] v;
    for (int t = 0; t < NTR; t++) v[t] = (fc[t] == DEP);
    return v;
  endfunction

  task automatic check_state(string req);
    check({req, " cfg"}, 192'(cfg_q), 192'(cfg_flat()));
    check({req, " underflow"}, 192'(trig_underflow), 192'(uf_m));
    check({req, " full"}, 192'(dev_full), 192'(full_m()));
  endtask

  // Model per requirements: window 0x4000_0000, page = addr[11:8]
  task automatic acc(string req, logic we, logic [31:0] a, logic [31:0] wd);
    logic inblk = (a[31:12] == 20'h40000);
    logic al = (a[1:0] == 2'b00);
    int pg = a[11:8], wi = a[7:2], tb = a[7:4];
    logic [31:0] exp = 0;
    if (inblk && al && !we) begin
      if (pg == 0 && wi < NRW) exp = cfg_m[wi];
      if (pg == 2 && a[3:2] == 0 && tb < NTR) begin
        if (fc[tb] > 0) begin
          exp = fq[tb][0];
          for (int k = 0; k < DEP - 1; k++) fq[tb][k] = fq[tb][k+1];
          fc[tb]--;
        end else uf_m[tb] = 1'b1;
      end
    end
    if (inblk && al && we && pg == 1 && wi < NRW) cfg_m[wi] = wd;
    @(negedge clk);
    bus_sel = 1; bus_we = we; bus_addr = a; bus_wdata = wd;
    @(negedge clk);
    bus_sel = 0;
    check({req, " R1 ack"}, 192'(bus_ack), 192'(inblk));
    check({req, " R1 cinh"}, 192'(bus_cinh), 192'(inblk));
    check({req, " rdata"}, 192'(bus_rdata), 192'(exp));
    check_state(req);
  endtask

  task automatic push(string req, int t, logic [31:0] d);
    if (fc[t] < DEP) begin fq[t][fc[t]] = d; fc[t]++; end
    @(negedge clk);
    dev_push = '0; dev_push[t] = 1'b1; dev_data[t*DW +: DW] = d;
    @(negedge clk);
    dev_push = '0;
    check_state(req);
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NRW; i++) cfg_m[i] = 0;
    for (int t = 0; t < NTR; t++) fc[t] = 0;
    uf_m = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R10 ack", 192'(bus_ack), 0);
    check("R10 cinh", 192'(bus_cinh), 0);
    check_state("R10");

    acc("R2 write", 1, 32'h4000_0108, 32'hDEAD_BEEF);
    acc("R3 read", 0, 32'h4000_0008, 0);
    acc("R4 read wr port", 0, 32'h4000_0108, 0);
    acc("R4 write rd port", 1, 32'h4000_0008, 32'h1234_5678);
    acc("R3 reread", 0, 32'h4000_0008, 0);
    acc("R8 index beyond", 0, 32'h4000_0018, 0);
    acc("R8 write beyond", 1, 32'h4000_0118, 32'hFFFF_FFFF);
    acc("R1 miss read", 0, 32'h5000_0008, 0);
    acc("R1 miss write", 1, 32'h5000_0108, 32'h1);
    for (int k = 0; k < DEP + 1; k++) push("R9 fill", 1, 32'hA000_0000 + k);
    check("R9 full", 192'(dev_full[1]), 1);
    for (int k = 0; k < DEP; k++) acc("R5 drain", 0, 32'h4000_0210, 0);
    acc("R6 empty read", 0, 32'h4000_0210, 0);
    check("R6 flag", 192'(trig_underflow), 192'(3'b010));
    push("R7 prep", 0, 32'h0BAD_CAFE);
    acc("R7 neighbour +4", 0, 32'h4000_0204, 0);
    acc("R7 neighbour +C", 0, 32'h4000_020C, 0);
    acc("R8 misaligned", 0, 32'h4000_0202, 0);
    acc("R8 page3", 0, 32'h4000_0300, 0);
    acc("R8 block3", 0, 32'h4000_0230, 0);
    acc("R11 write trig", 1, 32'h4000_0200, 32'h5555_5555);
    acc("R5 R7 R11 value kept", 0, 32'h4000_0200, 0);

    for (int n = 0; n < 600; n++) begin
      int op = $urandom_range(0, 8);
      int t = $urandom_range(0, NTR - 1);
      logic [31:0] a;
      case (op)
        0: acc("R2 rnd", 1, 32'h4000_0100 + 4 * $urandom_range(0, 7), $urandom);
        1: acc("R3 rnd", 0, 32'h4000_0000 + 4 * $urandom_range(0, 7), 0);
        2: acc("R4 rnd", 0, 32'h4000_0100 + 4 * $urandom_range(0, 7), 0);
        3: acc("R4 rnd wr", 1, 32'h4000_0000 + 4 * $urandom_range(0, 7), $urandom);
        4: acc("R5 R6 rnd", 0, 32'h4000_0200 + 16 * $urandom_range(0, 3), 0);
        5: push("R9 rnd", t, $urandom);
        6: push("R9 rnd2", t, $urandom);
        7: begin
          a = 32'h4000_0000 | (32'($urandom) & 32'h0000_0FFF);
          acc("R8 rnd", $urandom_range(0, 1), a, $urandom);
        end
        default: acc("R1 rnd miss", $urandom_range(0, 1), $urandom | 32'h8000_0000, $urandom);
      endcase
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule